// File: doc/BRIEF.md
# Multi-format serial audio input receiver

This block sits behind a serial audio input port and recovers parallel samples from it. It runs on the incoming bit clock. On every rising edge it samples a frame clock and three serial data lines. Each data line carries one stereo pair, so the port delivers six channels in total. Every word arrives most significant bit first in two's complement form.

Four framings can be selected. In left-justified framing the word starts on the first bit of a frame clock half. In I2S framing it starts one bit later. In right-justified framing the word ends on the last bit of the half. In pulse framing a one-bit sync pulse marks the frame, and the two words follow it back to back. Words may be 16, 20 or 24 bits long. A packed mode takes all six channels on data line 0 as 32-bit slots, in the order pair 1 left, pair 1 right, pair 2 left, pair 2 right, pair 3 left, pair 3 right.

The framing, the word length and the packed mode are static configuration, held steady while the block runs. When every channel of a frame has been captured, the six 24-bit outputs update together and a one-cycle strobe is raised.

Top module: `audio_serial_rx`

## Requirements
- R1: While reset is high, and on the first cycle after it, `ch_valid` is 0 and every `ch_data` field is 0.
- R2: With `fmt_sel`=0 (left-justified), frame clock high marks the left half. The MSB is the first bit sampled in a half. `ch_valid` rises in the cycle after the right word's LSB is sampled.
- R3: With `fmt_sel`=1 (I2S), frame clock low marks the left half. The MSB is the second bit of a half. The strobe follows the right word's LSB.
- R4: With `fmt_sel`=2 (right-justified), frame clock high marks the left half. The LSB is the last bit before a frame clock change. The strobe appears after the first bit of the following left half is sampled.
- R5: With `fmt_sel`=3 (pulse), a rising frame clock on one bit marks the frame start. The left word begins on the next bit and the right word follows it directly. The strobe follows the right word's LSB.
- R6: `wlen_sel` 0, 1 and 2 (and 3) give word lengths of 16, 20 and 24 (and 24). A shorter word sits in the upper bits of its 24-bit field with zeros below. Bits outside the word have no effect.
- R7: With `packed_en`=1, a rising frame clock starts a frame on `sdin[0]` of six 32-bit slots. Each word is left-justified in its slot, and slot n goes to channel n. `sdin[2:1]` is ignored.
- R8: `ch_valid` lasts exactly one cycle. All six fields change only in a cycle where `ch_valid` is 1.
- R9: A frame with no preceding left word, or a packed frame cut short by a new frame start, produces no strobe and leaves the outputs unchanged.
- R10: Channel c occupies `ch_data[24c+23:24c]`. Channel 2k is the left word and channel 2k+1 the right word of `sdin[k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; all sampling on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fmt_sel | input | 2 | Framing: 0 left-justified, 1 I2S, 2 right-justified, 3 pulse |
| wlen_sel | input | 2 | Word length: 0 = 16, 1 = 20, 2 or 3 = 24 bits |
| packed_en | input | 1 | Six channels in 32-bit slots on data line 0 |
| lrclk | input | 1 | Frame clock or frame sync |
| sdin | input | 3 | Serial data lines, one stereo pair each |
| ch_data | output | 144 | Six 24-bit channel samples, channel 0 in the low bits |
| ch_valid | output | 1 | One-cycle strobe marking a new complete frame |

## Verification
In right-justified framing, two events share one sampled bit: the frame clock change that ends the right word, and the first bit of the next left word. The stimulus runs frames back to back, so that bit carries both the completion and the start of the next frame. The reference model expects the strobe and the finished frame in the cycle after that bit. It also expects the next frame's left word to report correctly one frame later.

The same collision is provoked in packed mode. A frame is cut off after two slots, so the new frame start lands while the slot record is still partial. The model requires that no strobe appears, that the outputs stay unchanged, and that the next full frame is reported intact.

// File: rtl/arx_pkg.sv
package arx_pkg;
  typedef enum logic [1:0] {
    FMT_LEFT_J  = 2'd0,
    FMT_I2S     = 2'd1,
    FMT_RIGHT_J = 2'd2,
    FMT_PULSE   = 2'd3
  } frame_fmt_e;

  typedef enum logic [1:0] {
    WL_SHORT    = 2'd0,
    WL_MID      = 2'd1,
    WL_FULL     = 2'd2,
    WL_FULL_ALT = 2'd3
  } word_len_e;
endpackage

// File: rtl/arx_frame_timer.sv
module arx_frame_timer #(
  parameter int POS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lr,
  input  logic             rise_only,
  output logic             lr_q,
  output logic             anchor,
  output logic [POS_W-1:0] pos_now,
  output logic [POS_W-1:0] pos_q
);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic primed_q;
  logic edge_seen;

  // No edge is trusted until one bit has been sampled after reset
  assign edge_seen = primed_q && (lr != lr_q);
  assign anchor    = rise_only ? (edge_seen && lr) : edge_seen;

  always_comb begin
    if (anchor)                pos_now = '0;
    else if (pos_q == POS_MAX) pos_now = POS_MAX;
    else                       pos_now = pos_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      primed_q <= 1'b0;
      lr_q     <= 1'b0;
      pos_q    <= POS_MAX;
    end else begin
      primed_q <= 1'b1;
      lr_q     <= lr;
      pos_q    <= pos_now;
    end
  end
endmodule

// File: rtl/arx_lane_shift.sv
module arx_lane_shift #(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sd,
  output logic [SAMPLE_W-1:0] sr_q,
  output logic [SAMPLE_W-1:0] sr_next
);
  assign sr_next = {sr_q[SAMPLE_W-2:0], sd};

  always_ff @(posedge clk) begin
    if (rst) sr_q <= '0;
    else     sr_q <= sr_next;
  end
endmodule

// File: rtl/arx_capture_ctl.sv
module arx_capture_ctl
  import arx_pkg::*;
#(
  parameter int SAMPLE_W  = 24,
  parameter int SLOT_BITS = 32,
  parameter int NSLOT     = 6,
  parameter int POS_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  frame_fmt_e       fmt,
  input  word_len_e        wlen,
  input  logic             packed_en,
  input  logic             anchor,
  input  logic             lr,
  input  logic             lr_q,
  input  logic [POS_W-1:0] pos_now,
  input  logic [POS_W-1:0] pos_q,
  output logic             cap_left,
  output logic             cap_right,
  output logic             use_prev,
  output logic [NSLOT-1:0] slot_cap,
  output logic [POS_W-1:0] wshift
);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic [POS_W-1:0] wl;
  logic             rj_hit;

  always_comb begin
    case (wlen)
      WL_SHORT: wl = POS_W'(SAMPLE_W - 8);
      WL_MID:   wl = POS_W'(SAMPLE_W - 4);
      default:  wl = POS_W'(SAMPLE_W);
    endcase
  end

  assign wshift = POS_W'(SAMPLE_W) - wl;

  // Right-justified: the word just ended on the previous half, which must have been long enough
  assign rj_hit = anchor && (pos_q != POS_MAX) && (pos_q >= wl - 1'b1);

  always_comb begin
    cap_left  = 1'b0;
    cap_right = 1'b0;
    use_prev  = 1'b0;
    if (!packed_en) begin
      case (fmt)
        FMT_LEFT_J: begin
          cap_left  = (pos_now == wl - 1'b1) && lr;
          cap_right = (pos_now == wl - 1'b1) && !lr;
        end
        FMT_I2S: begin
          cap_left  = (pos_now == wl) && !lr;
          cap_right = (pos_now == wl) && lr;
        end
        FMT_RIGHT_J: begin
          use_prev  = 1'b1;
          cap_left  = rj_hit && lr_q;
          cap_right = rj_hit && !lr_q;
        end
        FMT_PULSE: begin
          cap_left  = (pos_now == wl);
          cap_right = (pos_now == (wl << 1));
        end
        default: ;
      endcase
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam logic [POS_W-1:0] BASE = POS_W'(s * SLOT_BITS);
    assign slot_cap[s] = packed_en && (pos_now == BASE + wl - 1'b1);
  end

  // R7
  slot_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(slot_cap));
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import arx_pkg::*;
#(
  parameter int SAMPLE_W  = 24,
  parameter int SLOT_BITS = 32,
  parameter int LANES     = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [1:0]                    fmt_sel,
  input  logic [1:0]                    wlen_sel,
  input  logic                          packed_en,
  input  logic                          lrclk,
  input  logic [LANES-1:0]              sdin,
  output logic [2*LANES*SAMPLE_W-1:0]   ch_data,
  output logic                          ch_valid
);
  localparam int NCH   = 2 * LANES;
  localparam int POS_W = $clog2(NCH * SLOT_BITS + 1);

  frame_fmt_e       fmt;
  word_len_e        wlen;
  logic             lr_q;
  logic             anchor;
  logic [POS_W-1:0] pos_now;
  logic [POS_W-1:0] pos_q;
  logic             cap_left;
  logic             cap_right;
  logic             use_prev;
  logic [NCH-1:0]   slot_cap;
  logic [POS_W-1:0] wshift;

  logic [SAMPLE_W-1:0] sr_q_a  [LANES];
  logic [SAMPLE_W-1:0] sr_nx_a [LANES];
  logic [SAMPLE_W-1:0] algn    [LANES];
  logic [SAMPLE_W-1:0] hold    [NCH-1];
  logic [SAMPLE_W-1:0] outr    [NCH];
  logic [NCH-2:0]      slot_mask;
  logic                left_seen;

  assign fmt  = frame_fmt_e'(fmt_sel);
  assign wlen = word_len_e'(wlen_sel);

  arx_frame_timer #(.POS_W(POS_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .lr        (lrclk),
    .rise_only (packed_en || (fmt == FMT_PULSE)),
    .lr_q      (lr_q),
    .anchor    (anchor),
    .pos_now   (pos_now),
    .pos_q     (pos_q)
  );

  arx_capture_ctl #(
    .SAMPLE_W  (SAMPLE_W),
    .SLOT_BITS (SLOT_BITS),
    .NSLOT     (NCH),
    .POS_W     (POS_W)
  ) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .fmt       (fmt),
    .wlen      (wlen),
    .packed_en (packed_en),
    .anchor    (anchor),
    .lr        (lrclk),
    .lr_q      (lr_q),
    .pos_now   (pos_now),
    .pos_q     (pos_q),
    .cap_left  (cap_left),
    .cap_right (cap_right),
    .use_prev  (use_prev),
    .slot_cap  (slot_cap),
    .wshift    (wshift)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    arx_lane_shift #(.SAMPLE_W(SAMPLE_W)) u_shift (
      .clk     (clk),
      .rst     (rst),
      .sd      (sdin[i]),
      .sr_q    (sr_q_a[i]),
      .sr_next (sr_nx_a[i])
    );
    // Shorter words move to the top of the field; zeros fill in below
    assign algn[i] = (use_prev ? sr_q_a[i] : sr_nx_a[i]) << wshift;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCH - 1; c++) hold[c] <= '0;
      for (int c = 0; c < NCH; c++)     outr[c] <= '0;
      slot_mask <= '0;
      left_seen <= 1'b0;
      ch_valid  <= 1'b0;
    end else begin
      ch_valid <= 1'b0;
      if (packed_en) begin
        for (int c = 0; c < NCH - 1; c++)
          if (slot_cap[c]) hold[c] <= algn[0];
        if (anchor) begin
          slot_mask <= '0;
        end else if (slot_cap[NCH-1]) begin
          slot_mask <= '0;
          if (&slot_mask) begin
            for (int c = 0; c < NCH - 1; c++) outr[c] <= hold[c];
            outr[NCH-1] <= algn[0];
            ch_valid    <= 1'b1;
          end
        end else begin
          slot_mask <= slot_mask | slot_cap[NCH-2:0];
        end
      end else begin
        if (cap_left) begin
          for (int i = 0; i < LANES; i++) hold[2*i] <= algn[i];
          left_seen <= 1'b1;
        end
        if (cap_right) begin
          left_seen <= 1'b0;
          if (left_seen) begin
            for (int i = 0; i < LANES; i++) begin
              outr[2*i]   <= hold[2*i];
              outr[2*i+1] <= algn[i];
            end
            ch_valid <= 1'b1;
          end
        end
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_flat
    assign ch_data[c*SAMPLE_W +: SAMPLE_W] = outr[c];
  end

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ch_valid |=> !ch_valid);

  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ch_valid |-> $stable(ch_data));

  // R7
  packed_src_chk: assert property (@(posedge clk) disable iff (rst)
    (ch_valid && packed_en) |-> $past(slot_cap[NCH-1]));

  // R9
  pair_src_chk: assert property (@(posedge clk) disable iff (rst)
    (ch_valid && !packed_en) |-> $past(cap_right));
endmodule

// File: tb/audio_serial_rx_tb.sv
module audio_serial_rx_tb;
  localparam int SW   = 24;
  localparam int SLOT = 32;
  localparam int NCH  = 6;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [1:0]        fmt_sel = 2'd0;
  logic [1:0]        wlen_sel = 2'd2;
  logic              packed_en = 1'b0;
  logic              lrclk = 1'b0;
  logic [2:0]        sdin = 3'd0;
  logic [NCH*SW-1:0] ch_data;
  logic              ch_valid;

  always #4 clk = ~clk;

  audio_serial_rx u_dut (
    .clk       (clk),
    .rst       (rst),
    .fmt_sel   (fmt_sel),
    .wlen_sel  (wlen_sel),
    .packed_en (packed_en),
    .lrclk     (lrclk),
    .sdin      (sdin),
    .ch_data   (ch_data),
    .ch_valid  (ch_valid)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  bit pend     = 1'b0;
  string tag   = "R1";

  bit                q_lr[$];
  logic [2:0]        q_sd[$];
  bit                q_fl[$];
  logic [NCH*SW-1:0] q_exp[$];
  logic [NCH*SW-1:0] model = '0;

  function automatic logic [SW-1:0] rnd_word(input int w);
    logic [SW-1:0] r;
    r = SW'($urandom);
    return r & ~({SW{1'b1}} >> w);
  endfunction

  function automatic logic [1:0] wcode(input int w);
    return (w == 16) ? 2'd0 : (w == 20) ? 2'd1 : 2'd2;
  endfunction

  task automatic push(input bit lr, input logic [2:0] sd, input bit fl);
    q_lr.push_back(lr);
    q_sd.push_back(sd);
    q_fl.push_back(fl | pend);
    pend = 1'b0;
  endtask

  task automatic idle(input bit lr, input int n);
    for (int k = 0; k < n; k++) push(lr, 3'($urandom), 1'b0);
  endtask

  // f: 0 left-justified, 1 I2S, 2 right-justified
  task automatic stereo_frame(input int f, input int w);
    logic [SW-1:0]     s [NCH];
    logic [NCH*SW-1:0] e;
    for (int c = 0; c < NCH; c++) begin
      s[c] = rnd_word(w);
      e[c*SW +: SW] = s[c];
    end
    q_exp.push_back(e);
    for (int h = 0; h < 2; h++) begin
      for (int k = 0; k < SLOT; k++) begin
        bit         lr;
        bit         fl;
        int         st;
        logic [2:0] sd;
        lr = (f == 1) ? (h == 1) : (h == 0);
        st = (f == 0) ? 0 : (f == 1) ? 1 : SLOT - w;
        for (int i = 0; i < 3; i++) begin
          if (k >= st && k < st + w) sd[i] = s[2*i+h][SW-1-(k-st)];
          else                       sd[i] = 1'($urandom);
        end
        fl = (h == 1) && ((f == 0 && k == w - 1) || (f == 1 && k == w));
        push(lr, sd, fl);
      end
    end
    if (f == 2) pend = 1'b1;
  endtask

  task automatic pulse_frame(input int w);
    logic [SW-1:0]     s [NCH];
    logic [NCH*SW-1:0] e;
    for (int c = 0; c < NCH; c++) begin
      s[c] = rnd_word(w);
      e[c*SW +: SW] = s[c];
    end
    q_exp.push_back(e);
    for (int k = 0; k < 2 * SLOT; k++) begin
      logic [2:0] sd;
      for (int i = 0; i < 3; i++) begin
        if (k >= 1 && k <= w)          sd[i] = s[2*i][SW-k];
        else if (k > w && k <= 2 * w)  sd[i] = s[2*i+1][SW-(k-w)];
        else                           sd[i] = 1'($urandom);
      end
      push(k == 0, sd, k == 2 * w);
    end
  endtask

  task automatic packed_frame(input int w, input int nslot);
    logic [SW-1:0]     s [NCH];
    logic [NCH*SW-1:0] e;
    bit                full;
    full = (nslot == NCH);
    for (int c = 0; c < NCH; c++) begin
      s[c] = rnd_word(w);
      e[c*SW +: SW] = s[c];
    end
    if (full) q_exp.push_back(e);
    for (int k = 0; k < nslot * SLOT; k++) begin
      logic [2:0] sd;
      int         sl;
      int         kk;
      sl = k / SLOT;
      kk = k % SLOT;
      sd = 3'($urandom);
      if (kk < w) sd[0] = s[sl][SW-1-kk];
      push(k < (NCH / 2) * SLOT, sd, full && sl == NCH - 1 && kk == w - 1);
    end
    if (!full) push(1'b0, 3'($urandom), 1'b0);
  endtask

  task automatic compare(input bit fl);
    if (fl && q_exp.size() > 0) model = q_exp.pop_front();
    n_checks++;
    if (ch_valid !== fl) begin
      n_fail++;
      $display("FAIL %s R8 strobe: got %0b expected %0b", tag, ch_valid, fl);
    end
    n_checks++;
    if (ch_data !== model) begin
      n_fail++;
      $display("FAIL %s R10 data: got %h expected %h", tag, ch_data, model);
    end
  endtask

  task automatic drain();
    while (q_lr.size() > 0) begin
      bit fl;
      lrclk = q_lr.pop_front();
      sdin  = q_sd.pop_front();
      fl    = q_fl.pop_front();
      @(negedge clk);
      compare(fl);
    end
  endtask

  task automatic start(input int f, input int w, input bit pk, input bit lvl, input string t);
    rst       = 1'b1;
    fmt_sel   = 2'(f);
    wlen_sel  = wcode(w);
    packed_en = pk;
    lrclk     = 1'b0;
    sdin      = 3'd0;
    repeat (2) @(negedge clk);
    // R1: outputs cleared by reset
    n_checks++;
    if (ch_data !== '0 || ch_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset state: got valid=%0b data=%h expected 0", ch_valid, ch_data);
    end
    rst   = 1'b0;
    model = '0;
    pend  = 1'b0;
    q_exp.delete();
    tag   = t;
    idle(lvl, 4);
  endtask

  initial begin
    @(negedge clk);

    start(0, 24, 1'b0, 1'b0, "R2 R10");
    repeat (3) stereo_frame(0, 24);
    idle(1'b0, 4); drain();

    start(0, 16, 1'b0, 1'b0, "R6 16-bit");
    repeat (2) stereo_frame(0, 16);
    idle(1'b0, 4); drain();

    start(0, 20, 1'b0, 1'b0, "R6 20-bit");
    repeat (2) stereo_frame(0, 20);
    idle(1'b0, 4); drain();

    start(1, 24, 1'b0, 1'b1, "R3");
    repeat (3) stereo_frame(1, 24);
    idle(1'b1, 4); drain();

    start(1, 16, 1'b0, 1'b1, "R3 R6");
    stereo_frame(1, 16);
    idle(1'b1, 4); drain();

    start(2, 24, 1'b0, 1'b0, "R4");
    repeat (2) stereo_frame(2, 24);
    idle(1'b1, 4); drain();

    start(2, 20, 1'b0, 1'b0, "R4 R6");
    repeat (2) stereo_frame(2, 20);
    idle(1'b1, 4); drain();

    start(3, 24, 1'b0, 1'b0, "R5");
    repeat (2) pulse_frame(24);
    idle(1'b0, 4); drain();

    start(3, 16, 1'b0, 1'b0, "R5 R6");
    pulse_frame(16);
    idle(1'b0, 4); drain();

    start(0, 24, 1'b1, 1'b0, "R7");
    repeat (2) packed_frame(24, NCH);
    idle(1'b0, 4); drain();

    start(0, 20, 1'b1, 1'b0, "R7 R6");
    packed_frame(20, NCH);
    idle(1'b0, 4); drain();

    // R9: packed frame cut short, then a full one
    start(0, 24, 1'b1, 1'b0, "R9 packed");
    packed_frame(24, 2);
    packed_frame(24, NCH);
    idle(1'b0, 4); drain();

    // R9: a right half with no left before it, then a full frame
    start(0, 24, 1'b0, 1'b1, "R9 stereo");
    for (int k = 0; k < SLOT; k++) push(1'b0, 3'($urandom), 1'b0);
    stereo_frame(0, 24);
    idle(1'b0, 4); drain();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R8 watchdog: got no end expected end of run");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule